// File: doc/BRIEF.md
# Filter Trim Alignment Controller

This block turns three active-low mode pins into one of four operating states (sleep, alignment, receive, transmit) and, while in the alignment state, steers a 7-bit trim code for the intermediate-frequency filter and discriminator capacitor banks. It runs on the reference tone clock. A divider turns that clock into a slow step: on each step the trim code moves one level toward the side the discriminator sign comparator reports.

When alignment ends, because the code has converged or the mode pins have moved to receive or transmit, the code is held. Sleep, or any pin pattern that the mode table does not list, puts the code back to its centre so that the next wake-up must align again. A strap input turns the alignment loop off and leaves the code where it is. A done flag reports that the loop has finished. It rises either after the full step budget or early, once the comparator sign has flipped on several steps in a row, which shows that the code is dithering about the centre.

Top module: `filter_trim_ctrl`

## Requirements
- R1: The mode pins decode as follows. All three high gives sleep. `rx_sel_n`=1, `tx_sel_n`=1, `chip_en_n`=0 gives align. `rx_sel_n`=0, `tx_sel_n`=1, `chip_en_n`=0 gives receive. `rx_sel_n`=1, `tx_sel_n`=0, `chip_en_n`=0 gives transmit. Every other pattern gives sleep. Exactly one of the four mode enables is high at all times.
- R2: In active alignment the trim code changes at most once per 16 reference clocks. The first step is taken on the 16th clock edge after the edge on which alignment was first seen, and each later step follows 16 edges after the one before it.
- R3: On a step, `cmp_hi`=1 raises the trim code by one and `cmp_hi`=0 lowers it by one.
- R4: The trim code saturates at 0 and at 127.
- R5: Reset and any sleep cycle set the trim code to the mid value 64, taking effect at the next clock edge.
- R6: In receive and transmit the trim code holds its value and ignores `cmp_hi`. A later alignment resumes from the held value.
- R7: While `align_off`=1, the align mode enable still decodes, but the trim code does not move and the done flag stays low.
- R8: The done flag rises on the 128th step of an alignment run. Once it is high the trim code stops moving.
- R9: The done flag rises early on the step that completes four consecutive steps, each with a comparator sign opposite to the step before it. The first step of a run has no earlier sign.
- R10: The done flag is held through receive and transmit. It clears when alignment is entered again or on sleep.
- R11: The three trim outputs always carry the same value as `trim_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference tone clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sel_n | input | 1 | Active-low receive select pin |
| tx_sel_n | input | 1 | Active-low transmit select pin |
| chip_en_n | input | 1 | Active-low chip enable pin |
| cmp_hi | input | 1 | Discriminator sign: 1 means centre frequency too high |
| align_off | input | 1 | Strap: 1 disables the alignment loop |
| sleep_en | output | 1 | Sleep mode enable |
| align_en | output | 1 | Alignment mode enable |
| rx_en | output | 1 | Receive mode enable |
| tx_en | output | 1 | Transmit mode enable |
| trim_code | output | 7 | Current trim code |
| trim_if_a | output | 7 | Trim word for first IF filter bank |
| trim_if_b | output | 7 | Trim word for second IF filter bank |
| trim_disc | output | 7 | Trim word for discriminator bank |
| align_done | output | 1 | Alignment finished |

## Verification
Two functions can fall in the same cycle: the step that saturates the code and the step that ends the run. The 128-step budget is reached right after a long upward run pinned at 127 and a downward run back off it. The alternation exit is provoked while the code sits at 0, so the clamp and the early done flag act together. Both are judged against step counts and trim values worked out in the bench. Mode-pin changes are also made exactly on alignment entry and exit, and the bench checks that done clears on entry and is held in receive and transmit.

// File: rtl/filter_trim_ctrl.sv
module filter_trim_ctrl #(
  parameter int REF_DIV   = 16,
  parameter int TRIM_W    = 7,
  parameter int MAX_STEPS = 128,
  parameter int ALT_RUN   = 4
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              rx_sel_n,
  input  logic              tx_sel_n,
  input  logic              chip_en_n,
  input  logic              cmp_hi,
  input  logic              align_off,
  output logic              sleep_en,
  output logic              align_en,
  output logic              rx_en,
  output logic              tx_en,
  output logic [TRIM_W-1:0] trim_code,
  output logic [TRIM_W-1:0] trim_if_a,
  output logic [TRIM_W-1:0] trim_if_b,
  output logic [TRIM_W-1:0] trim_disc,
  output logic              align_done
);
  localparam int DIV_W  = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam int STEP_W = $clog2(MAX_STEPS + 1);
  localparam int ALT_W  = $clog2(ALT_RUN + 1);
  localparam logic [TRIM_W-1:0] TRIM_MID = TRIM_W'(1 << (TRIM_W - 1));
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};

  logic [DIV_W-1:0]  div_q;
  logic [STEP_W-1:0] steps_q;
  logic [ALT_W-1:0]  alt_q;
  logic [TRIM_W-1:0] trim_q;
  logic              act_q, have_sign_q, last_sign_q, done_q;
  logic              align_act, entry, run, step, toggle;

  assign align_en  = rx_sel_n  & tx_sel_n  & ~chip_en_n;
  assign rx_en     = ~rx_sel_n & tx_sel_n  & ~chip_en_n;
  assign tx_en     = rx_sel_n  & ~tx_sel_n & ~chip_en_n;
  assign sleep_en  = ~(align_en | rx_en | tx_en);

  assign align_act = align_en & ~align_off;
  assign entry     = align_act & ~act_q;
  assign run       = align_act & act_q & ~done_q;
  assign step      = run && (div_q == DIV_W'(REF_DIV - 1));
  assign toggle    = have_sign_q && (cmp_hi != last_sign_q);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q       <= 1'b0;
      div_q       <= '0;
      steps_q     <= '0;
      alt_q       <= '0;
      trim_q      <= TRIM_MID;
      have_sign_q <= 1'b0;
      last_sign_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      act_q <= align_act;
      if (sleep_en) begin
        trim_q      <= TRIM_MID;
        div_q       <= '0;
        steps_q     <= '0;
        alt_q       <= '0;
        have_sign_q <= 1'b0;
        done_q      <= 1'b0;
      end else if (entry) begin
        div_q       <= '0;
        steps_q     <= '0;
        alt_q       <= '0;
        have_sign_q <= 1'b0;
        done_q      <= 1'b0;
      end else if (run) begin
        div_q <= step ? '0 : div_q + 1'b1;
        if (step) begin
          if (cmp_hi && trim_q != TRIM_MAX)
            trim_q <= trim_q + 1'b1;
          else if (!cmp_hi && trim_q != '0)
            trim_q <= trim_q - 1'b1;
          steps_q     <= steps_q + 1'b1;
          have_sign_q <= 1'b1;
          last_sign_q <= cmp_hi;
          alt_q       <= toggle ? alt_q + 1'b1 : '0;
          if (steps_q == STEP_W'(MAX_STEPS - 1) ||
              (toggle && alt_q == ALT_W'(ALT_RUN - 1)))
            done_q <= 1'b1;
        end
      end
    end
  end

  assign trim_code  = trim_q;
  assign trim_if_a  = trim_q;
  assign trim_if_b  = trim_q;
  assign trim_disc  = trim_q;
  assign align_done = done_q;

  p_onehot_mode_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $onehot({sleep_en, align_en, rx_en, tx_en}));

  p_sleep_mid_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sleep_en |=> trim_code == TRIM_MID);

  p_hold_outside_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (rx_en || tx_en) |=> $stable(trim_code));

  p_strap_still_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (align_en && align_off) |=> ($stable(trim_code) && !align_done));

  p_unit_move_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !sleep_en |=> ({1'b0, trim_code} == {1'b0, $past(trim_code)} ||
                   {1'b0, trim_code} == {1'b0, $past(trim_code)} + 1'b1 ||
                   {1'b0, trim_code} + 1'b1 == {1'b0, $past(trim_code)}));

  p_done_freeze_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (align_done && !sleep_en) |=> $stable(trim_code));

  p_done_sticky_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (align_done && !sleep_en && !entry) |=> align_done);
endmodule

// File: tb/filter_trim_ctrl_tb_top.sv
module filter_trim_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rs = 1'b1, ts = 1'b1, loe = 1'b1, cmp = 1'b0, strap = 1'b0;
  logic sleep_en, align_en, rx_en, tx_en, done;
  logic [6:0] trim, ta, tb, tdisc;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  filter_trim_ctrl dut_i (
    .ref_clk(clk), .rst_n(rst_n), .rx_sel_n(rs), .tx_sel_n(ts), .chip_en_n(loe),
    .cmp_hi(cmp), .align_off(strap), .sleep_en(sleep_en), .align_en(align_en),
    .rx_en(rx_en), .tx_en(tx_en), .trim_code(trim), .trim_if_a(ta), .trim_if_b(tb),
    .trim_disc(tdisc), .align_done(done));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_trim(string req, int exp);
    chk(req, trim, exp);
    chk({req, "/R11"}, (ta == trim && tb == trim && tdisc == trim) ? 1 : 0, 1);
  endtask

  task automatic pins(logic r, logic t, logic l);
    @(negedge clk);
    rs = r; ts = t; loe = l;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(logic s, int n);
    for (int k = 0; k < n; k++) begin
      cmp = s;
      repeat (16) @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_trim("R5 reset mid", 64);
    chk("R10 reset done", done, 0);
    chk("R1 reset sleep", sleep_en, 1);
    rst_n = 1'b1;

    // R1 exhaustive decode sweep
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rs = i[2]; ts = i[1]; loe = i[0];
      #1;
      begin
        int ea, er, et, es;
        ea = (i[2] && i[1] && !i[0]) ? 1 : 0;
        er = (!i[2] && i[1] && !i[0]) ? 1 : 0;
        et = (i[2] && !i[1] && !i[0]) ? 1 : 0;
        es = (ea + er + et == 0) ? 1 : 0;
        chk("R1 align_en", align_en, ea);
        chk("R1 rx_en", rx_en, er);
        chk("R1 tx_en", tx_en, et);
        chk("R1 sleep_en", sleep_en, es);
      end
    end

    // enter align: entry edge, then R2 timing
    pins(1, 1, 0);
    cmp = 1'b1;
    repeat (15) @(posedge clk);
    @(negedge clk);
    chk_trim("R2 no step before 16 edges", 64);
    @(posedge clk);
    @(negedge clk);
    chk_trim("R2 first step / R3 up", 65);
    steps(0, 5);
    chk_trim("R3 down", 60);
    steps(1, 70);
    chk_trim("R4 saturate high", 127);
    steps(0, 51);
    chk("R8 done low at step 127", done, 0);
    chk_trim("R3 after 127 steps", 76);
    steps(0, 1);
    chk("R8 done at step 128", done, 1);
    chk_trim("R8 trim at 128", 75);
    steps(1, 3);
    chk_trim("R8 frozen after done", 75);

    // receive / transmit hold
    pins(0, 1, 0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cmp = k[0];
    end
    @(negedge clk);
    chk_trim("R6 hold in receive", 75);
    chk("R10 done held in receive", done, 1);
    pins(1, 0, 0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cmp = ~k[0];
    end
    @(negedge clk);
    chk_trim("R6 hold in transmit", 75);
    chk("R10 done held in transmit", done, 1);

    // re-enter align: done clears, resume from held code
    pins(1, 1, 0);
    chk("R10 done clears on entry", done, 0);
    steps(0, 1);
    chk_trim("R6 resume from held", 74);
    steps(0, 79);
    chk_trim("R4 saturate low", 0);
    chk("R8 no done before budget", done, 0);

    // R9 alternation exit while clamped at zero
    steps(1, 1);
    steps(0, 1);
    steps(1, 1);
    chk("R9 done low after 3 toggles", done, 0);
    chk_trim("R9 trim dithering", 1);
    steps(0, 1);
    chk("R9 done after 4 toggles", done, 1);
    chk_trim("R9 trim at exit", 0);

    // sleep
    pins(1, 1, 1);
    chk_trim("R5 sleep mid", 64);
    chk("R10 sleep clears done", done, 0);

    // strap
    @(negedge clk);
    strap = 1'b1;
    pins(1, 1, 0);
    steps(1, 3);
    chk("R7 align_en decodes", align_en, 1);
    chk_trim("R7 strap no movement", 64);
    chk("R7 strap no done", done, 0);
    pins(1, 1, 1);
    @(negedge clk);
    strap = 1'b0;

    // illegal pattern resets
    pins(1, 1, 0);
    steps(1, 2);
    chk_trim("R3 up twice", 66);
    pins(0, 1, 0);
    chk_trim("R6 held", 66);
    pins(0, 0, 0);
    chk("R1 illegal is sleep", sleep_en, 1);
    chk_trim("R5 illegal resets mid", 64);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule